// File: doc/BRIEF.md
# PLL operating mode controller

This block decides which operating mode a network-synchronization PLL runs in. The modes are reset, free-run, manual holdover, automatic holdover and normal (locked). Software picks a target through a 2-bit mode-select field. The block combines that choice with reference-health and loop-status inputs and walks a five-state machine.

The machine can enter holdover by itself when the reference disappears. It leaves holdover for normal once the acquisition loop has left its own holdover and the core loop reports lock. After an automatic holdover, a control bit chooses how the machine returns to normal:

- With the bit clear, the return happens on its own when the reference recovers.
- With the bit set, the return waits for a complete software release pulse.

One mode-select code forces free-run from any state. The loops, detectors and register bus are outside the block and appear only as status inputs.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` reads 0 (reset) and both status outputs are 0. On the first clock edge with `rst_n` high, the state becomes free-run (`mode` = 1).
- R2: When `mode_sel` = 2'b10 at a clock edge, the next state is free-run, whatever the current state and the other inputs.
- R3: In free-run, `mode_sel` = 2'b00 (normal) or 2'b01 (holdover) moves the machine to manual holdover (`mode` = 2).
- R4: In manual holdover, the machine moves to normal (`mode` = 4) only in a cycle where all of these hold: `mode_sel` = 2'b00, `ref_ok` = 1, `acq_holdover` = 0 and `core_lock` = 1. Otherwise it stays in manual holdover, including for as long as the reference is absent.
- R5: In normal or automatic holdover, either `mode_sel` = 2'b01 or a high `ref_switch` strobe moves the machine to manual holdover. This takes precedence over any reference event in the same cycle.
- R6: In normal with `mode_sel` = 2'b00, a fall of `ref_ok` (1 in the previous cycle, 0 now) moves the machine to automatic holdover (`mode` = 3).
- R7: In automatic holdover with `mode_sel` = 2'b00 and `auto_ret_dis` = 0, a rise of `ref_ok` (0 in the previous cycle, 1 now) returns the machine to normal.
- R8: In automatic holdover with `auto_ret_dis` = 1, a rise of `ref_ok` is ignored. Normal is re-entered only in the following case:
  - `man_release` first rises while the machine is in automatic holdover, and
  - `man_release` later falls in a cycle with `ref_ok` = 1 and `mode_sel` = 2'b00.
- R9: The release rise is forgotten whenever the machine leaves automatic holdover. A rise seen in another state does not count, so a later fall alone does not return the machine to normal.
- R10: `locked` is 1 exactly in normal. `in_holdover` is 1 exactly in manual or automatic holdover. The two are never 1 together.
- R11: `mode_sel` = 2'b11 issues no command. It leaves free-run and normal unchanged, and in normal it blocks the automatic holdover entry of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; holds the reset state |
| mode_sel | input | 2 | Requested mode: 00 normal, 01 holdover, 10 free-run, 11 no command |
| ref_ok | input | 1 | Selected reference is valid |
| ref_switch | input | 1 | One-cycle strobe: the selected reference was changed |
| auto_ret_dis | input | 1 | 1 = after automatic holdover, wait for a software release pulse |
| man_release | input | 1 | Software release bit; a 0-1-0 pulse returns from automatic holdover |
| acq_holdover | input | 1 | Acquisition loop is still in its own holdover |
| core_lock | input | 1 | Core loop reports lock |
| mode | output | 3 | State: 0 reset, 1 free-run, 2 manual holdover, 3 automatic holdover, 4 normal |
| locked | output | 1 | High in normal |
| in_holdover | output | 1 | High in either holdover state |

## Verification
A directed pass walks the start-up path: free-run, then holdover with no reference, a missing acquisition status and a missing core lock, then normal. This separates each gating condition of R4 from the others.

The pass then drives two reference drop-and-recover cycles, one with the return-disable bit at 0 and one at 1. This shows automatic return apart from release-pulse return, and shows that a reference rise is ignored while the return is disabled.

A release rise taken before a detour through manual holdover, followed by a fall in automatic holdover, tests that the armed flag is forgotten. A mode-select of 11 in normal during a reference drop tests R11.

After that, biased random stimulus mixes every input, including sparse resets. A bench model checks every cycle, which exercises the priority between the free-run force, manual commands and reference edges.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  localparam int unsigned PM_MODE_W = 3;
  localparam int unsigned PM_SEL_W  = 2;

  typedef enum logic [PM_MODE_W-1:0] {
    PM_RESET    = 3'd0,
    PM_FREERUN  = 3'd1,
    PM_HOLD     = 3'd2,
    PM_AUTOHOLD = 3'd3,
    PM_NORMAL   = 3'd4
  } pm_mode_e;

  localparam logic [PM_SEL_W-1:0] SEL_NORMAL = 2'b00;
  localparam logic [PM_SEL_W-1:0] SEL_HOLD   = 2'b01;
  localparam logic [PM_SEL_W-1:0] SEL_FREE   = 2'b10;

  // Per-cycle view of everything the transition function depends on
  typedef struct packed {
    logic [PM_SEL_W-1:0] sel;
    logic                ref_ok;
    logic                ref_rose;
    logic                ref_fell;
    logic                ref_switch;
    logic                ret_dis;
    logic                rel_done;
    logic                acq_hold;
    logic                core_lock;
  } pm_ev_t;

  // Transition function; priority: free-run force, manual commands, reference events
  function automatic pm_mode_e pm_next(input pm_mode_e cur, input pm_ev_t ev);
    pm_mode_e nx;
    logic     manual_hold;
    logic     auto_ret;
    nx          = cur;
    manual_hold = (ev.sel == SEL_HOLD) || ev.ref_switch;
    auto_ret    = (ev.sel == SEL_NORMAL) &&
                  ((!ev.ret_dis && ev.ref_rose) || (ev.rel_done && ev.ref_ok));
    if (cur == PM_RESET) begin
      nx = PM_FREERUN;
    end else if (ev.sel == SEL_FREE) begin
      nx = PM_FREERUN;
    end else begin
      case (cur)
        PM_FREERUN:
          if (ev.sel != 2'b11) nx = PM_HOLD;
        PM_HOLD:
          if (ev.sel == SEL_NORMAL && ev.ref_ok && !ev.acq_hold && ev.core_lock)
            nx = PM_NORMAL;
        PM_NORMAL:
          if (manual_hold) nx = PM_HOLD;
          else if (ev.sel == SEL_NORMAL && ev.ref_fell) nx = PM_AUTOHOLD;
        PM_AUTOHOLD:
          if (manual_hold) nx = PM_HOLD;
          else if (auto_ret) nx = PM_NORMAL;
        default: nx = PM_FREERUN;
      endcase
    end
    return nx;
  endfunction

endpackage

// File: rtl/pmc_edge_det.sv
module pmc_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] din_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) din_q[i] <= 1'b0;
      else        din_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~din_q[i];
    assign fall[i] = ~din[i] & din_q[i];
  end

endmodule

// File: rtl/pmc_release_arm.sv
module pmc_release_arm
  import pll_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_e state,
  input  pm_mode_e state_nx,
  input  logic     rel_rise,
  input  logic     rel_fall,
  output logic     armed,
  output logic     rel_done
);

  logic stay_auto;

  assign stay_auto = (state == PM_AUTOHOLD) && (state_nx == PM_AUTOHOLD);
  assign rel_done  = armed & rel_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= stay_auto & (armed | rel_rise);
  end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pll_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_ev_t   ev,
  output pm_mode_e state,
  output pm_mode_e state_nx
);

  assign state_nx = pm_next(state, ev);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PM_RESET;
    else        state <= state_nx;
  end

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PM_SEL_W-1:0]  mode_sel,
  input  logic                 ref_ok,
  input  logic                 ref_switch,
  input  logic                 auto_ret_dis,
  input  logic                 man_release,
  input  logic                 acq_holdover,
  input  logic                 core_lock,
  output logic [PM_MODE_W-1:0] mode,
  output logic                 locked,
  output logic                 in_holdover
);

  localparam int unsigned EDGE_W  = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_REL = 1;

  logic [EDGE_W-1:0] edge_rise;
  logic [EDGE_W-1:0] edge_fall;
  logic              ref_rose;
  logic              ref_fell;
  logic              rel_rise;
  logic              rel_fall;
  logic              armed;
  logic              rel_done;
  pm_ev_t            ev;
  pm_mode_e          state;
  pm_mode_e          state_nx;

  pmc_edge_det #(.W(EDGE_W)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({man_release, ref_ok}),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  assign ref_rose = edge_rise[IDX_REF];
  assign ref_fell = edge_fall[IDX_REF];
  assign rel_rise = edge_rise[IDX_REL];
  assign rel_fall = edge_fall[IDX_REL];

  always_comb begin
    ev.sel        = mode_sel;
    ev.ref_ok     = ref_ok;
    ev.ref_rose   = ref_rose;
    ev.ref_fell   = ref_fell;
    ev.ref_switch = ref_switch;
    ev.ret_dis    = auto_ret_dis;
    ev.rel_done   = rel_done;
    ev.acq_hold   = acq_holdover;
    ev.core_lock  = core_lock;
  end

  pmc_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .state   (state),
    .state_nx(state_nx)
  );

  pmc_release_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .state_nx(state_nx),
    .rel_rise(rel_rise),
    .rel_fall(rel_fall),
    .armed   (armed),
    .rel_done(rel_done)
  );

  assign mode        = state;
  assign locked      = (state == PM_NORMAL);
  assign in_holdover = (state == PM_HOLD) || (state == PM_AUTOHOLD);

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk
  import pll_mode_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [PM_SEL_W-1:0]  mode_sel,
  input logic                 ref_ok,
  input logic                 ref_switch,
  input logic                 auto_ret_dis,
  input logic                 acq_holdover,
  input logic                 core_lock,
  input logic [PM_MODE_W-1:0] mode,
  input logic                 locked,
  input logic                 in_holdover,
  input logic                 ref_fell,
  input logic                 armed
);

  // R1
  reset_hold_chk: assert property (@(posedge clk)
    !rst_n |=> mode == PM_RESET);

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == PM_RESET |=> mode == PM_FREERUN);

  // R2
  force_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == SEL_FREE |=> mode == PM_FREERUN);

  // R4
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_HOLD && !ref_ok && mode_sel != SEL_FREE) |=> mode == PM_HOLD);

  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(mode) == PM_AUTOHOLD ||
                       ($past(core_lock) && !$past(acq_holdover))));

  // R6
  auto_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NORMAL && mode_sel == SEL_NORMAL && !ref_switch && ref_fell)
      |=> mode == PM_AUTOHOLD);

  // R8
  no_unarmed_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_AUTOHOLD && auto_ret_dis && !armed) |=> mode != PM_NORMAL);

  // R10
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({locked, in_holdover}));

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .ref_ok      (ref_ok),
  .ref_switch  (ref_switch),
  .auto_ret_dis(auto_ret_dis),
  .acq_holdover(acq_holdover),
  .core_lock   (core_lock),
  .mode        (mode),
  .locked      (locked),
  .in_holdover (in_holdover),
  .ref_fell    (ref_fell),
  .armed       (armed)
);

// File: tb/pll_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pll_mode_ctrl_tb;

  localparam int ST_RST = 0, ST_FREE = 1, ST_HOLD = 2, ST_AUTO = 3, ST_NORM = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b10;
  logic       ref_ok = 1'b0, sw = 1'b0, dis = 1'b0, rel = 1'b0, acq = 1'b1, lock = 1'b0;
  logic [2:0] mode;
  logic       locked, in_holdover;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  int   m_st = ST_RST;
  logic m_refq = 1'b0, m_relq = 1'b0, m_arm = 1'b0;

  always #10 clk = ~clk;

  pll_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(sel), .ref_ok(ref_ok), .ref_switch(sw),
    .auto_ret_dis(dis), .man_release(rel), .acq_holdover(acq), .core_lock(lock),
    .mode(mode), .locked(locked), .in_holdover(in_holdover)
  );

  function automatic int model_next(int st);
    logic up, down, done;
    up   = ref_ok && !m_refq;
    down = !ref_ok && m_refq;
    done = m_arm && !rel && m_relq;
    if (st == ST_RST || sel == 2'b10) return ST_FREE;
    if (st == ST_FREE) return (sel == 2'b11) ? ST_FREE : ST_HOLD;
    if (st == ST_HOLD)
      return (sel == 2'b00 && ref_ok && !acq && lock) ? ST_NORM : ST_HOLD;
    if (sel == 2'b01 || sw) return ST_HOLD;
    if (st == ST_NORM) return (sel == 2'b00 && down) ? ST_AUTO : ST_NORM;
    if (sel == 2'b00 && ((!dis && up) || (done && ref_ok))) return ST_NORM;
    return ST_AUTO;
  endfunction

  task automatic model_clock();
    int nx;
    if (!rst_n) begin
      m_st = ST_RST; m_refq = 1'b0; m_relq = 1'b0; m_arm = 1'b0;
    end else begin
      nx     = model_next(m_st);
      m_arm  = (m_st == ST_AUTO && nx == ST_AUTO) && (m_arm || (rel && !m_relq));
      m_st   = nx;
      m_refq = ref_ok;
      m_relq = rel;
    end
  endtask

  task automatic step(input string tag);
    logic xl, xh;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    xl = (m_st == ST_NORM);
    xh = (m_st == ST_HOLD) || (m_st == ST_AUTO);
    n_chk++;
    if (int'(mode) != m_st || locked !== xl || in_holdover !== xh) begin
      n_err++;
      $display("FAIL %s: mode=%0d locked=%0b hold=%0b expected mode=%0d locked=%0b hold=%0b",
               tag, mode, locked, in_holdover, m_st, xl, xh);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    // R1 reset hold and exit
    step("R1 reset"); step("R1 reset");
    rst_n = 1'b1; step("R1 exit to free-run");
    // R11 no command in free-run
    sel = 2'b11; step("R11 free-run kept");
    // R3 free-run to holdover
    sel = 2'b00; step("R3 to holdover");
    // R4 no reference: stay
    step("R4 wait no ref"); step("R4 wait no ref");
    ref_ok = 1'b1; step("R4 acq still holdover");
    acq = 1'b0; step("R4 core not locked");
    lock = 1'b1; step("R4 enter normal, R10 locked");
    // R6 drop then R7 automatic return
    ref_ok = 1'b0; step("R6 auto holdover");
    ref_ok = 1'b1; step("R7 auto return");
    // R8 return disabled
    ref_ok = 1'b0; step("R6 auto holdover again");
    dis = 1'b1; ref_ok = 1'b1; step("R8 rise ignored");
    step("R8 stay");
    rel = 1'b1; step("R8 armed");
    rel = 1'b0; step("R8 release to normal");
    // R9 armed flag cleared on leaving
    ref_ok = 1'b0; step("R6 drop");
    rel = 1'b1; step("R8 arm");
    sw = 1'b1; step("R5 ref switch to holdover");
    sw = 1'b0; ref_ok = 1'b1; step("R4 back to normal");
    ref_ok = 1'b0; step("R6 drop");
    rel = 1'b0; step("R9 stale release ignored");
    ref_ok = 1'b1; step("R8 dis=1 rise ignored");
    // R5 manual holdover from auto holdover and from normal
    sel = 2'b01; step("R5 manual holdover");
    sel = 2'b00; step("R4 normal");
    sel = 2'b01; step("R5 normal to holdover");
    sel = 2'b00; step("R4 normal");
    // R11 no command blocks auto entry
    sel = 2'b11; ref_ok = 1'b0; step("R11 normal kept");
    // R2 forced free-run
    sel = 2'b10; step("R2 force free-run");
    // random phase
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = int'($urandom % 16);
      sel = (r < 11 || r == 15) ? 2'b00 : (r < 13) ? 2'b01 : (r == 13) ? 2'b10 : 2'b11;
      if ($urandom % 6 == 0) ref_ok = ~ref_ok;
      sw = ($urandom % 20 == 0);
      if ($urandom % 10 == 0) dis = ~dis;
      if ($urandom % 4 == 0) rel = ~rel;
      acq  = ($urandom % 3 == 0);
      lock = ($urandom % 3 != 0);
      rst_n = ($urandom % 200 != 0);
      step("random R2 R4 R5 R6 R7 R8 R9 R10");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule